// File: doc/BRIEF.md
# Exception Entry Stack-and-Vector Sequencer

This block carries out the memory work of entering an exception handler once the core has accepted a trap. A one-cycle start strobe hands it the vector number, the return address and snapshots of the status word, the stack pointer and the vector base. The block writes the status word to the stack first and the return address second. It then reads the handler address from the vector table and reports it as the new program counter, together with the lowered stack pointer. The core jumps to that address directly. The jump has no delay slot, so no instruction after the trap executes before the handler.

The memory side is a valid/ready request port that has at most one access in flight. The block raises `mem_valid_o` and holds the address, the write enable and the write data unchanged until `mem_ready_i` is high on a rising clock edge. A transfer completes on any edge where valid and ready are both high. For a read, `mem_rdata_i` is sampled on that same edge. Ready may stay low for any number of cycles. The block ignores start strobes from its start cycle until one cycle after its done pulse.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `mem_valid_o` are 0.
- R2: The first access of an entry is a write (`mem_we_o`=1) of `sr_i` to address `sp_i - 4`.
- R3: The second access is a write of `ret_pc_i` to address `sp_i - 8`.
- R4: The third access is a read (`mem_we_o`=0) from address `vbr_i + 4*vec_num_i`.
- R5: While `mem_valid_o` is 1 and `mem_ready_i` is 0, the request stays asserted and its address, write enable and write data are unchanged on the next cycle.
- R6: On the cycle after the read transfer, `done_o` is 1 for exactly one cycle. In that cycle `new_pc_o` equals the data read and `new_sp_o` equals `sp_i - 8`.
- R7: Start strobes are ignored while busy, which covers the whole sequence and the done cycle. No extra access occurs, and the stored values are not replaced.
- R8: Each entry makes exactly three accesses, and `mem_valid_o` is 0 whenever the block is not busy.
- R9: Stack and vector address arithmetic wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an entry (accepted only when idle) |
| vec_num_i | input | VEC_W | Vector number |
| ret_pc_i | input | AW | Return address to save |
| sr_i | input | DW | Status word to save |
| sp_i | input | AW | Current stack pointer |
| vbr_i | input | AW | Vector table base |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory accepts / completes request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Request address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid with ready |
| busy_o | output | 1 | Entry in progress |
| done_o | output | 1 | One-cycle completion pulse |
| new_pc_o | output | AW | Handler address fetched |
| new_sp_o | output | AW | Stack pointer after the pushes |

## Verification
The bench holds ready low for several cycles on every access to test back-pressure. A design that moved on without a handshake would drop or repeat a push. A design that let its address drift during a stall would write the wrong stack slot. Start strobes are injected in the middle of an entry and on the done cycle. A design that restarted would show a fourth access or saved values taken from the injected inputs. A stack pointer of 4 with a high vector base and vector 255 tests wrap-around. A back-to-back restart checks that no state is carried from the previous entry.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PUSH_SR = 3'd1,
    ST_PUSH_PC = 3'd2,
    ST_FETCH   = 3'd3,
    ST_DONE    = 3'd4
  } ent_state_e;

  localparam int WORD_SHIFT = 2;
endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       xfer_i,
  output ent_state_e state_o,
  output logic       accept_o,
  output logic       busy_o,
  output logic       done_o
);
  ent_state_e state_q, state_d;

  assign accept_o = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_PUSH_SR;
      ST_PUSH_SR: if (xfer_i)  state_d = ST_PUSH_PC;
      ST_PUSH_PC: if (xfer_i)  state_d = ST_FETCH;
      ST_FETCH:   if (xfer_i)  state_d = ST_DONE;
      ST_DONE:                 state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = (state_q == ST_DONE);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && start_i) |=> busy_o); // R7
endmodule

// File: rtl/exc_entry_regs.sv
module exc_entry_regs
  import exc_entry_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ent_state_e       state_i,
  input  logic             accept_i,
  input  logic             xfer_i,
  input  logic [VEC_W-1:0] vec_num_i,
  input  logic [AW-1:0]    ret_pc_i,
  input  logic [DW-1:0]    sr_i,
  input  logic [AW-1:0]    sp_i,
  input  logic [AW-1:0]    vbr_i,
  input  logic [DW-1:0]    rdata_i,
  output logic [AW-1:0]    sp_o,
  output logic [AW-1:0]    ret_pc_o,
  output logic [DW-1:0]    sr_o,
  output logic [AW-1:0]    vaddr_o,
  output logic [AW-1:0]    pc_o
);
  localparam int PAD_W = AW - VEC_W - WORD_SHIFT;
  localparam logic [AW-1:0] WORD_BYTES = AW'(1) << WORD_SHIFT;

  logic [AW-1:0] vec_off;
  assign vec_off = {{PAD_W{1'b0}}, vec_num_i, {WORD_SHIFT{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_o     <= '0;
      ret_pc_o <= '0;
      sr_o     <= '0;
      vaddr_o  <= '0;
      pc_o     <= '0;
    end else if (accept_i) begin
      sp_o     <= sp_i - WORD_BYTES;
      ret_pc_o <= ret_pc_i;
      sr_o     <= sr_i;
      vaddr_o  <= vbr_i + vec_off;
    end else if (xfer_i) begin
      if (state_i == ST_PUSH_SR) sp_o <= sp_o - WORD_BYTES;
      if (state_i == ST_FETCH)   pc_o <= AW'(rdata_i);
    end
  end

  AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_i && state_i == ST_PUSH_SR) |=> (sp_o == $past(sp_o) - WORD_BYTES)); // R3
endmodule

// File: rtl/exc_entry_memport.sv
module exc_entry_memport
  import exc_entry_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  ent_state_e    state_i,
  input  logic [AW-1:0] sp_i,
  input  logic [AW-1:0] ret_pc_i,
  input  logic [DW-1:0] sr_i,
  input  logic [AW-1:0] vaddr_i,
  output logic          valid_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);
  always_comb begin
    valid_o = 1'b0;
    we_o    = 1'b0;
    addr_o  = '0;
    wdata_o = '0;
    unique case (state_i)
      ST_PUSH_SR: begin
        valid_o = 1'b1; we_o = 1'b1; addr_o = sp_i; wdata_o = sr_i;
      end
      ST_PUSH_PC: begin
        valid_o = 1'b1; we_o = 1'b1; addr_o = sp_i; wdata_o = DW'(ret_pc_i);
      end
      ST_FETCH: begin
        valid_o = 1'b1; we_o = 1'b0; addr_o = vaddr_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [VEC_W-1:0] vec_num_i,
  input  logic [AW-1:0]    ret_pc_i,
  input  logic [DW-1:0]    sr_i,
  input  logic [AW-1:0]    sp_i,
  input  logic [AW-1:0]    vbr_i,
  output logic             mem_valid_o,
  input  logic             mem_ready_i,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [AW-1:0]    new_pc_o,
  output logic [AW-1:0]    new_sp_o
);
  ent_state_e    state;
  logic          accept, xfer;
  logic [AW-1:0] sp_q, ret_q, vaddr_q;
  logic [DW-1:0] sr_q;

  assign xfer = mem_valid_o && mem_ready_i;

  exc_entry_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .xfer_i(xfer),
    .state_o(state), .accept_o(accept), .busy_o(busy_o), .done_o(done_o)
  );

  exc_entry_regs #(.AW(AW), .DW(DW), .VEC_W(VEC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .state_i(state), .accept_i(accept), .xfer_i(xfer),
    .vec_num_i(vec_num_i), .ret_pc_i(ret_pc_i), .sr_i(sr_i), .sp_i(sp_i),
    .vbr_i(vbr_i), .rdata_i(mem_rdata_i), .sp_o(sp_q), .ret_pc_o(ret_q),
    .sr_o(sr_q), .vaddr_o(vaddr_q), .pc_o(new_pc_o)
  );

  exc_entry_memport #(.AW(AW), .DW(DW)) u_port (
    .state_i(state), .sp_i(sp_q), .ret_pc_i(ret_q), .sr_i(sr_q),
    .vaddr_i(vaddr_q), .valid_o(mem_valid_o), .we_o(mem_we_o),
    .addr_o(mem_addr_o), .wdata_o(mem_wdata_o)
  );

  assign new_sp_o = sp_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o))); // R5
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_valid_o); // R8
  AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(mem_valid_o && mem_ready_i && !mem_we_o)); // R6
  AST_PC_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && mem_ready_i && !mem_we_o) |=> (done_o && new_pc_o == $past(mem_rdata_i))); // R6
endmodule

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  vec_num_i = '0;
  logic [31:0] ret_pc_i = '0, sr_i = '0, sp_i = '0, vbr_i = '0;
  logic        mem_valid_o, mem_ready_i = 1'b0, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic        busy_o, done_o;
  logic [31:0] new_pc_o, new_sp_o;

  int errors = 0, checks = 0, cycles = 0;
  int stall = 0, wcnt = 0, n_acc = 0;
  logic        lg_we [8];
  logic [31:0] lg_addr [8], lg_data [8];

  always #2 clk = ~clk;

  exc_entry_seq i_exc_entry_seq (.*);

  assign mem_rdata_i = mem_addr_o ^ 32'h5A5A_0000;

  always @(negedge clk) begin
    if (mem_valid_o) begin
      if (wcnt >= stall) begin mem_ready_i <= 1'b1; wcnt = 0; end
      else begin mem_ready_i <= 1'b0; wcnt++; end
    end else begin
      mem_ready_i <= 1'b0; wcnt = 0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (mem_valid_o && mem_ready_i) begin
      if (n_acc < 8) begin
        lg_we[n_acc] = mem_we_o;
        lg_addr[n_acc] = mem_addr_o;
        lg_data[n_acc] = mem_we_o ? mem_wdata_o : mem_rdata_i;
      end
      n_acc++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    finish_run();
  end

  // One entry; poke=1 injects starts mid-sequence and on the done cycle (R7)
  task automatic run_entry(input string name, input logic [31:0] sp, input logic [31:0] pc,
                           input logic [31:0] sr, input logic [7:0] vec,
                           input logic [31:0] vbr, input int stl, input bit poke);
    logic [31:0] vaddr;
    int n;
    vaddr = vbr + {22'd0, vec, 2'b00};
    stall = stl;
    @(negedge clk);
    n_acc = 0;
    sp_i = sp; ret_pc_i = pc; sr_i = sr; vec_num_i = vec; vbr_i = vbr;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (!done_o && n < 200) begin
      if (poke && n == 2) begin
        start_i = 1'b1; sp_i = 32'h1111_1110; ret_pc_i = 32'hDEAD_0000;
        sr_i = 32'hFFFF_FFFF; vec_num_i = 8'h3; vbr_i = 32'h7000_0000;
      end else start_i = 1'b0;
      @(negedge clk);
      n++;
    end
    chk({name, " R6 done seen"}, 32'(done_o), 32'd1);
    chk({name, " R6 new_pc"}, new_pc_o, vaddr ^ 32'h5A5A_0000);
    chk({name, " R6 new_sp"}, new_sp_o, sp - 32'd8);
    if (poke) start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk({name, " R6 done one cycle"}, 32'(done_o), 32'd0);
    repeat (4) @(negedge clk);
    chk({name, " R8 access count"}, 32'(n_acc), 32'd3);
    chk({name, " R8 idle no request"}, 32'(mem_valid_o), 32'd0);
    chk({name, " R7 idle after sequence"}, 32'(busy_o), 32'd0);
    chk({name, " R2 sr write we"}, 32'(lg_we[0]), 32'd1);
    chk({name, " R2 sr addr"}, lg_addr[0], sp - 32'd4);
    chk({name, " R2 sr data"}, lg_data[0], sr);
    chk({name, " R3 pc write we"}, 32'(lg_we[1]), 32'd1);
    chk({name, " R3 pc addr"}, lg_addr[1], sp - 32'd8);
    chk({name, " R3 pc data"}, lg_data[1], pc);
    chk({name, " R4 read we"}, 32'(lg_we[2]), 32'd0);
    chk({name, " R4 vector addr"}, lg_addr[2], vaddr);
  endtask

  task automatic t_reset();
    chk("R1 busy", 32'(busy_o), 32'd0);
    chk("R1 done", 32'(done_o), 32'd0);
    chk("R1 valid", 32'(mem_valid_o), 32'd0);
  endtask

  task automatic t_stall();
    // R5: every access waits 3 cycles on ready; log must hold the first values
    run_entry("stall", 32'h0000_8000, 32'h0000_1236, 32'h0000_00F0, 8'd21, 32'h0000_0400, 3, 1'b0);
  endtask

  task automatic t_busy_poke();
    // R7
    run_entry("poke", 32'h2000_0100, 32'h0400_0002, 32'h0000_0301, 8'd64, 32'h1000_0000, 2, 1'b1);
  endtask

  task automatic t_wrap();
    // R9: sp=4 wraps stack below zero; vector address wraps above 2^32
    run_entry("wrap R9", 32'h0000_0004, 32'hFFFF_FFFE, 32'h8000_0001, 8'd255, 32'hFFFF_FF80, 1, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_entry("basic", 32'h0000_1000, 32'h0000_0A42, 32'h0000_00F3, 8'd33, 32'h0000_0000, 0, 1'b0);
    t_stall();
    t_busy_poke();
    t_wrap();
    run_entry("again R8", 32'h0010_0000, 32'h0000_0100, 32'h0, 8'd0, 32'h0000_2000, 0, 1'b0);
    finish_run();
  end
endmodule